// File: doc/BRIEF.md
# D-PHY Bring-Up Sequencer

This block walks a display serial transmitter's physical layer from its power-on reset state up to continuous high-speed clock transmission. It works without software in the loop. After a start pulse it releases the PHY's test-port clear. It then asks an external test-port master to write one PLL programming pair: code 0x44 with data 0x74, which sets 1 GHz from a 27 MHz reference. Once that write is done, the sequencer raises the three PHY control bits together and waits for the PLL to lock. It then waits for the clock lane to reach stop state, holds off for a configurable number of cycles, and finally requests the high-speed clock.

Each status wait has a cycle limit. If a wait runs past that limit, the sequencer raises an error flag and returns to idle with the PHY pushed back into power-down and reset. The start pulse also captures the lane-count code and the stop-wait time, which are presented unchanged to the rest of the controller until the next start.

Top module: `dphy_bringup`

## Requirements
- R1: After reset, the control word `phy_ctrl_o` (bit 0 shutdown release, bit 1 reset release, bit 2 clock-lane enable) is 3'b000. `test_clr_o` is 1, and `tp_req_o`, `hs_req_o`, `busy_o`, `done_o` and `timeout_o` are all 0.
- R2: A start pulse taken while idle drives `test_clr_o` to 0 in the following cycle. Only after that does `tp_req_o` rise, presenting code 0x44 on `tp_code_o` and 0x74 on `tp_data_o`, with the request held until `tp_done_i` is seen.
- R3: `phy_ctrl_o` stays 3'b000 until `tp_done_i` is sampled during a request. It becomes 3'b111 in the cycle after, and `tp_req_o` drops at the same time.
- R4: `hs_req_o` stays 0 until `pll_lock_i` has been seen high, and the clock-lane stop state `clk_stop_i` is only acted on after lock, even if it is already high earlier.
- R5: Once stop state is seen after lock, `hs_req_o` rises no fewer than `stop_wait` cycles later (latched value) and within `stop_wait`+4 cycles.
- R6: If either wait lasts more than `poll_limit_i`+1 cycles (latched value), `timeout_o` goes to 1, `busy_o` to 0, `phy_ctrl_o` to 3'b000, `test_clr_o` to 1, and `hs_req_o` stays 0.
- R7: A start pulse while `busy_o` is 1 is ignored: the control word, the latched configuration and the sequence continue unchanged.
- R8: `done_o` and `hs_req_o` stay 1 after a successful sequence until the next start pulse, which clears both and returns `phy_ctrl_o` to 3'b000.
- R9: `lanes_o` (00 = one lane, 01 = two, 10 = three, 11 = four) and `stop_wait_o` carry the values on `lanes_i` and `stop_wait_i` at the accepted start pulse. They stay stable whatever those inputs do later.
- R10: `busy_o` is 1 from the cycle after an accepted start until the cycle the sequence completes or times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse |
| lanes_i | input | 2 | Lane-count code to capture |
| stop_wait_i | input | 8 | Stop-to-HS wait in cycles, captured at start |
| poll_limit_i | input | CNT_W | Cycle limit for each status wait, captured at start |
| pll_lock_i | input | 1 | PHY PLL locked |
| clk_stop_i | input | 1 | PHY clock lane in stop state |
| tp_done_i | input | 1 | Test-port master finished the requested write |
| tp_req_o | output | 1 | Request a test-port code/data write |
| tp_code_o | output | 8 | Test code for the write |
| tp_data_o | output | 8 | Data for the write |
| test_clr_o | output | 1 | PHY test-port clear, active high |
| phy_ctrl_o | output | 3 | PHY control word: clock-lane enable, reset release, shutdown release |
| hs_req_o | output | 1 | High-speed clock request |
| lanes_o | output | 2 | Captured lane-count code |
| stop_wait_o | output | 8 | Captured stop-wait time |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |
| timeout_o | output | 1 | A status wait ran past its limit |

## Verification
The assertions take for granted that `tp_done_i` arrives only while `tp_req_o` is high and lasts one cycle. They also assume `start_i` is a pulse and `poll_limit_i` is at least 8. The bench keeps to this: it answers a request with one `tp_done_i` cycle only after seeing `tp_req_o`, and it drives start for a single cycle. It holds the lock and stop-state inputs low for fewer cycles than the limit of 20, except in the two cases meant to run out the lock wait and the stop wait.

// File: rtl/dphy_bringup_pkg.sv
package dphy_bringup_pkg;

    localparam logic [7:0] PLL_CODE = 8'h44;
    localparam logic [7:0] PLL_DATA = 8'h74;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_PLL,
        ST_LOCK,
        ST_STOP,
        ST_SETTLE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic lane_en;
        logic rst_rel;
        logic shdn_rel;
    } phy_ctrl_t;

    typedef struct packed {
        logic [1:0] lanes;
        logic [7:0] stop_wait;
    } link_cfg_t;

    function automatic phy_ctrl_t ctrl_all(input logic on);
        phy_ctrl_t c;
        c.lane_en  = on;
        c.rst_rel  = on;
        c.shdn_rel = on;
        return c;
    endfunction

    function automatic logic is_active(input seq_state_e s);
        return (s != ST_IDLE) && (s != ST_DONE);
    endfunction

endpackage

// File: rtl/dphy_wait_timer.sv
module dphy_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: counter never runs past its limit while a wait is active
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= limit));

endmodule

// File: rtl/dphy_cfg_hold.sv
module dphy_cfg_hold
    import dphy_bringup_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  link_cfg_t        cfg_in,
    input  logic [CNT_W-1:0] limit_in,
    output link_cfg_t        cfg_out,
    output logic [CNT_W-1:0] limit_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_out   <= '0;
            limit_out <= '0;
        end else if (load) begin
            cfg_out   <= cfg_in;
            limit_out <= limit_in;
        end
    end

    // R9: held configuration only moves on a load
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> ($stable(cfg_out) && $stable(limit_out)));

endmodule

// File: rtl/dphy_bringup.sv
module dphy_bringup
    import dphy_bringup_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       lanes_i,
    input  logic [7:0]       stop_wait_i,
    input  logic [CNT_W-1:0] poll_limit_i,
    input  logic             pll_lock_i,
    input  logic             clk_stop_i,
    input  logic             tp_done_i,
    output logic             tp_req_o,
    output logic [7:0]       tp_code_o,
    output logic [7:0]       tp_data_o,
    output logic             test_clr_o,
    output logic [2:0]       phy_ctrl_o,
    output logic             hs_req_o,
    output logic [1:0]       lanes_o,
    output logic [7:0]       stop_wait_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o
);
    localparam int PAD_W = CNT_W - 8;

    seq_state_e       state;
    phy_ctrl_t        ctrl_q;
    link_cfg_t        cfg_in;
    link_cfg_t        cfg_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] settle_lim;
    logic             start_go;
    logic             poll_run, poll_clear, poll_exp;
    logic             settle_run, settle_exp;
    logic             clr_q, hs_q, done_q, to_q;

    assign start_go = start_i && !is_active(state);

    assign cfg_in.lanes     = lanes_i;
    assign cfg_in.stop_wait = stop_wait_i;

    dphy_cfg_hold #(.CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (start_go),
        .cfg_in   (cfg_in),
        .limit_in (poll_limit_i),
        .cfg_out  (cfg_q),
        .limit_out(limit_q)
    );

    assign poll_run   = (state == ST_LOCK) || (state == ST_STOP);
    assign poll_clear = !poll_run || ((state == ST_LOCK) && pll_lock_i);

    dphy_wait_timer #(.CNT_W(CNT_W)) u_poll (
        .clk    (clk),
        .rst    (rst),
        .clear  (poll_clear),
        .run    (poll_run),
        .limit  (limit_q),
        .expired(poll_exp)
    );

    assign settle_run = (state == ST_SETTLE);
    assign settle_lim = {{PAD_W{1'b0}}, cfg_q.stop_wait};

    dphy_wait_timer #(.CNT_W(CNT_W)) u_settle (
        .clk    (clk),
        .rst    (rst),
        .clear  (!settle_run),
        .run    (settle_run),
        .limit  (settle_lim),
        .expired(settle_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ctrl_q <= ctrl_all(1'b0);
            clr_q  <= 1'b1;
            hs_q   <= 1'b0;
            done_q <= 1'b0;
            to_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start_go) begin
                        state  <= ST_CLR;
                        ctrl_q <= ctrl_all(1'b0);
                        clr_q  <= 1'b0;
                        hs_q   <= 1'b0;
                        done_q <= 1'b0;
                        to_q   <= 1'b0;
                    end
                end
                ST_CLR: state <= ST_PLL;
                ST_PLL: begin
                    if (tp_done_i) begin
                        ctrl_q <= ctrl_all(1'b1);
                        state  <= ST_LOCK;
                    end
                end
                ST_LOCK, ST_STOP: begin
                    if ((state == ST_LOCK) && pll_lock_i) begin
                        state <= ST_STOP;
                    end else if ((state == ST_STOP) && clk_stop_i) begin
                        state <= ST_SETTLE;
                    end else if (poll_exp) begin
                        state  <= ST_IDLE;
                        ctrl_q <= ctrl_all(1'b0);
                        clr_q  <= 1'b1;
                        to_q   <= 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (settle_exp) begin
                        hs_q   <= 1'b1;
                        done_q <= 1'b1;
                        state  <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tp_req_o    = (state == ST_PLL);
    assign tp_code_o   = PLL_CODE;
    assign tp_data_o   = PLL_DATA;
    assign test_clr_o  = clr_q;
    assign phy_ctrl_o  = ctrl_q;
    assign hs_req_o    = hs_q;
    assign lanes_o     = cfg_q.lanes;
    assign stop_wait_o = cfg_q.stop_wait;
    assign busy_o      = is_active(state);
    assign done_o      = done_q;
    assign timeout_o   = to_q;

    // R2: test write only with clear released and PHY still held down
    p_tp_in_reset_r2: assert property (@(posedge clk) disable iff (rst)
        tp_req_o |-> (!test_clr_o && phy_ctrl_o == 3'b000));

    // R3: control bits rise only after an acknowledged test write
    p_release_after_code_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_ctrl_o[0]) |-> $past(tp_req_o && tp_done_i));

    // R4: HS request only with the PHY fully released
    p_hs_released_r4: assert property (@(posedge clk) disable iff (rst)
        hs_req_o |-> (phy_ctrl_o == 3'b111 && !test_clr_o));

    // R6: timeout leaves PHY in reset and no HS request
    p_timeout_safe_r6: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (phy_ctrl_o == 3'b000 && !hs_req_o && test_clr_o && !busy_o));

    // R7: start while busy does not disturb the captured configuration
    p_ignore_start_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ($stable(lanes_o) && $stable(stop_wait_o)));

    // R8: done holds until a start arrives
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && hs_req_o));

    // R9: configuration outputs stable through a sequence
    p_cfg_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> ($stable(lanes_o) && $stable(stop_wait_o)));

    // R10: busy and done never overlap
    p_busy_done_r10: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && (done_o || timeout_o)));

endmodule

// File: tb/dphy_bringup_bench.sv
`timescale 1ns/1ps
module dphy_bringup_bench;
    localparam int CNT_W = 16;
    localparam int LIMIT = 20;
    localparam int NVEC  = 7;

    // {lanes[29:28], stop_wait[27:20], lock_delay[19:12], stop_delay[11:4], mode[3:0]}
    // mode 0 normal, 1 lock timeout, 2 stop timeout, 3 start while busy, 4 stop before lock
    localparam logic [29:0] VEC [NVEC] = '{
        {2'b00, 8'd0,   8'd0,  8'd0,  4'd0},
        {2'b11, 8'd5,   8'd3,  8'd2,  4'd0},
        {2'b10, 8'd200, 8'd10, 8'd12, 4'd0},
        {2'b01, 8'd3,   8'd0,  8'd0,  4'd1},
        {2'b01, 8'd7,   8'd5,  8'd0,  4'd2},
        {2'b10, 8'd9,   8'd4,  8'd3,  4'd3},
        {2'b11, 8'd4,   8'd8,  8'd0,  4'd4}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [1:0]       lanes_i = '0;
    logic [7:0]       stop_wait_i = '0;
    logic [CNT_W-1:0] poll_limit_i = CNT_W'(LIMIT);
    logic             pll_lock_i = 1'b0;
    logic             clk_stop_i = 1'b0;
    logic             tp_done_i = 1'b0;
    logic             tp_req_o;
    logic [7:0]       tp_code_o, tp_data_o;
    logic             test_clr_o;
    logic [2:0]       phy_ctrl_o;
    logic             hs_req_o;
    logic [1:0]       lanes_o;
    logic [7:0]       stop_wait_o;
    logic             busy_o, done_o, timeout_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dphy_bringup #(.CNT_W(CNT_W)) u_dphy_bringup (
        .clk(clk), .rst(rst), .start_i(start_i), .lanes_i(lanes_i),
        .stop_wait_i(stop_wait_i), .poll_limit_i(poll_limit_i),
        .pll_lock_i(pll_lock_i), .clk_stop_i(clk_stop_i), .tp_done_i(tp_done_i),
        .tp_req_o(tp_req_o), .tp_code_o(tp_code_o), .tp_data_o(tp_data_o),
        .test_clr_o(test_clr_o), .phy_ctrl_o(phy_ctrl_o), .hs_req_o(hs_req_o),
        .lanes_o(lanes_o), .stop_wait_o(stop_wait_o), .busy_o(busy_o),
        .done_o(done_o), .timeout_o(timeout_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check_reset_state(input string tag);
        check(phy_ctrl_o == 3'b000, {tag, " R1 ctrl"}, 32'(phy_ctrl_o), 0);
        check(test_clr_o == 1'b1, {tag, " R1 test_clr"}, 32'(test_clr_o), 1);
        check({tp_req_o, hs_req_o, busy_o, done_o, timeout_o} == 5'b0,
              {tag, " R1 flags"},
              32'({tp_req_o, hs_req_o, busy_o, done_o, timeout_o}), 0);
    endtask

    task automatic wait_timeout(input string req);
        int n = 0;
        while (!timeout_o && n < LIMIT + 10) begin
            @(negedge clk);
            n++;
        end
        check(timeout_o == 1'b1, {req, " timeout flag"}, 32'(timeout_o), 1);
        check(busy_o == 1'b0 && phy_ctrl_o == 3'b000, {req, " PHY back in reset"},
              32'({busy_o, phy_ctrl_o}), 0);
        check(test_clr_o == 1'b1 && hs_req_o == 1'b0, {req, " clear on, no HS"},
              32'({test_clr_o, hs_req_o}), 32'b10);
    endtask

    task automatic run_seq(input logic [1:0] ln, input logic [7:0] sw,
                           input int ld, input int sd, input int mode);
        bit seen = 0;
        int n = 0;
        @(negedge clk);
        lanes_i = ln; stop_wait_i = sw; pll_lock_i = 0; clk_stop_i = 0; start_i = 1;
        @(negedge clk);
        start_i = 0; lanes_i = ~ln; stop_wait_i = ~sw;
        check(busy_o == 1'b1, "R10 busy after start", 32'(busy_o), 1);
        check(test_clr_o == 1'b0, "R2 clear released", 32'(test_clr_o), 0);
        check(done_o == 1'b0 && timeout_o == 1'b0, "R8 flags cleared on start",
              32'({done_o, timeout_o}), 0);
        for (int i = 0; i < 10 && !seen; i++) begin
            if (tp_req_o) seen = 1;
            else @(negedge clk);
        end
        check(seen, "R2 test request", 32'(seen), 1);
        check(tp_code_o == 8'h44 && tp_data_o == 8'h74, "R2 code/data",
              32'({tp_code_o, tp_data_o}), 32'h4474);
        check(phy_ctrl_o == 3'b000, "R3 held before write", 32'(phy_ctrl_o), 0);
        repeat (3) @(negedge clk);
        check(tp_req_o == 1'b1, "R2 request held", 32'(tp_req_o), 1);
        tp_done_i = 1;
        @(negedge clk);
        tp_done_i = 0;
        check(phy_ctrl_o == 3'b111, "R3 release", 32'(phy_ctrl_o), 32'h7);
        check(tp_req_o == 1'b0, "R3 request dropped", 32'(tp_req_o), 0);
        if (mode == 4) clk_stop_i = 1;
        if (mode == 1) begin
            wait_timeout("R6 lock wait");
            return;
        end
        repeat (ld) @(negedge clk);
        if (mode == 3) begin
            start_i = 1; lanes_i = ln ^ 2'b01;
            @(negedge clk);
            start_i = 0;
            check(busy_o && phy_ctrl_o == 3'b111 && lanes_o == ln,
                  "R7 start ignored", 32'({busy_o, phy_ctrl_o, lanes_o}),
                  32'({1'b1, 3'b111, ln}));
        end
        check(hs_req_o == 1'b0, "R4 no HS before lock", 32'(hs_req_o), 0);
        pll_lock_i = 1;
        if (mode != 4) begin
            repeat (sd) @(negedge clk);
            check(hs_req_o == 1'b0, "R4 no HS before stop", 32'(hs_req_o), 0);
            if (mode == 2) begin
                wait_timeout("R6 stop wait");
                return;
            end
            clk_stop_i = 1;
        end
        while (!hs_req_o && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(hs_req_o == 1'b1, "R5 HS request", 32'(hs_req_o), 1);
        check(n >= int'(sw) && n <= int'(sw) + 4, "R5 stop-wait spacing", 32'(n), 32'(sw));
        check(done_o && !busy_o, "R10 done and idle", 32'({done_o, busy_o}), 32'b10);
        check(lanes_o == ln && stop_wait_o == sw, "R9 config latched",
              32'({lanes_o, stop_wait_o}), 32'({ln, sw}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("initial");
        rst = 0;
        @(negedge clk);
        check_reset_state("idle");

        for (int v = 0; v < NVEC; v++) begin
            run_seq(VEC[v][29:28], VEC[v][27:20], int'(VEC[v][19:12]),
                    int'(VEC[v][11:4]), int'(VEC[v][3:0]));
            pll_lock_i = 0;
            clk_stop_i = 0;
        end

        // R8: done holds, then a new start clears it
        run_seq(2'b01, 8'd2, 1, 1, 0);
        repeat (25) @(negedge clk);
        check(done_o && hs_req_o, "R8 done held", 32'({done_o, hs_req_o}), 32'b11);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        check(!done_o && !hs_req_o && phy_ctrl_o == 3'b000 && busy_o,
              "R8 restart clears", 32'({done_o, hs_req_o, phy_ctrl_o, busy_o}),
              32'b0000001);

        // R1: reset in mid-sequence
        rst = 1;
        repeat (2) @(negedge clk);
        check_reset_state("mid-sequence reset");
        rst = 0;
        @(negedge clk);
        check(busy_o == 1'b0, "R10 idle after reset", 32'(busy_o), 0);
        report();
    end

endmodule